// File: doc/BRIEF.md
# Coprocessor Compare Flag Unit

This block compares two operands read from a coprocessor register file and returns a 32-bit status word. The only bits of that word that can be set are the four condition flags: negative, zero, carry and overflow. Four compare variants exist:

- signed 32-bit integer
- signed 64-bit integer
- single-precision float
- double-precision float

The variant is decoded from a 3-bit opcode together with a bank select. The bank select tells whether the integer or the floating-point coprocessor is addressed.

An integer compare subtracts the second operand from the first and derives all four flags from that difference. A float compare is an ordered sign-magnitude comparison. It maps less-than to N, equality to Z and greater-than to C, and it always clears V. A NaN on either float input gives a status word with every flag clear.

Each request is accepted on a single-cycle valid strobe. One clock later the block either pulses `done_o` with a fresh status word, or pulses `illegal_o` for an opcode it does not support. In the illegal case the status word is left as it was.

Top module: `cmp_flag_unit`

## Requirements
- R1: The status word carries N at bit 31, Z at bit 30, C at bit 29 and V at bit 28. Bits 27 down to 0 are always zero.
- R2: With `bank_int_i`=1, opcode 4 selects the 32-bit integer compare and opcode 5 selects the 64-bit integer compare. With `bank_int_i`=0, opcode 4 selects the single-precision compare and opcode 5 selects the double-precision compare.
- R3: An integer compare computes the difference first minus second. Z is set when the difference is zero, and N is set when the top bit of the difference is set.
- R4: For an integer compare, V is set on signed overflow of the subtraction.
- R5: For an integer compare, C is set when the first operand is greater than or equal to the second as unsigned numbers (no borrow).
- R6: The 32-bit integer compare uses only bits 31:0 of each operand. The single-precision compare uses only bits 63:32 of each operand. The unused halves have no effect on the result.
- R7: A float compare sets Z on equality, N when the first operand is less than the second, and C when it is greater. V is always zero for a float compare.
- R8: For a float compare, +0 and -0 compare as equal.
- R9: If either float operand is a NaN, all four flags are zero.
- R10: `done_o` is high for exactly the one cycle after a cycle with `valid_i` high and a supported opcode. The status word updates at that same edge and holds its value otherwise.
- R11: For an opcode other than 4 or 5, `illegal_o` is high for the following cycle, `done_o` stays low, and the status word is unchanged.
- R12: While reset is asserted, `done_o`, `illegal_o` and the status word are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Request strobe, one cycle per compare |
| bank_int_i | input | 1 | 1 addresses the integer bank, 0 the float bank |
| opcode_i | input | 3 | Compare opcode (4 = narrow, 5 = wide) |
| opnd_a_i | input | 64 | First operand register value |
| opnd_b_i | input | 64 | Second operand register value |
| done_o | output | 1 | Result-ready pulse |
| illegal_o | output | 1 | Unsupported-opcode pulse |
| status_o | output | 32 | Status word holding the four flags |

## Verification
Every piece of state in this block is visible at the ports one clock after it is written: the done pulse, the illegal pulse and the held status word. A wrong decode or a wrong flag term therefore shows up as a mismatched status word on the very cycle of `done_o`. A stuck pulse register or a status word that updates when it should not shows up on the next idle or illegal cycle. The bench compares all three outputs against its own model on every clock. The stimulus covers:

- equality, less-than and greater-than for each variant
- signed overflow in both widths
- negative floats and signed zeros
- NaN operands and infinities
- junk in the unused halves of the operands

// File: rtl/cfu_pkg.sv
package cfu_pkg;

  typedef enum logic [1:0] {
    KIND_I32 = 2'd0,
    KIND_I64 = 2'd1,
    KIND_F32 = 2'd2,
    KIND_F64 = 2'd3
  } cmp_kind_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  localparam int STATUS_W = 32;
  localparam int BIT_N    = 31;
  localparam int BIT_Z    = 30;
  localparam int BIT_C    = 29;
  localparam int BIT_V    = 28;

endpackage

// File: rtl/cfu_decode.sv
module cfu_decode
  import cfu_pkg::*;
#(
  parameter int          OPC_W      = 3,
  parameter logic [2:0]  OPC_NARROW = 3'd4,
  parameter logic [2:0]  OPC_WIDE   = 3'd5
) (
  input  logic             bank_int,
  input  logic [OPC_W-1:0] opcode,
  output cmp_kind_e        kind,
  output logic             legal
);

  always_comb begin
    kind  = KIND_I32;
    legal = 1'b0;
    if (opcode == OPC_NARROW) begin
      legal = 1'b1;
      kind  = bank_int ? KIND_I32 : KIND_F32;
    end else if (opcode == OPC_WIDE) begin
      legal = 1'b1;
      kind  = bank_int ? KIND_I64 : KIND_F64;
    end
  end

endmodule

// File: rtl/cfu_int_cmp.sv
module cfu_int_cmp
  import cfu_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output nzcv_t        flags
);

  localparam int MSB = W - 1;

  logic [W-1:0] diff;
  logic         sa, sb, sr;

  always_comb begin
    diff    = a - b;
    sa      = a[MSB];
    sb      = b[MSB];
    sr      = diff[MSB];
    flags.n = sr;
    flags.z = (diff == '0);
    flags.v = (sa != sb) && (sr != sa);
    flags.c = (sa && !sb) || (sa && !sr) || (!sb && !sr);
  end

endmodule

// File: rtl/cfu_fp_cmp.sv
module cfu_fp_cmp
  import cfu_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] a,
  input  logic [EXP_W+MAN_W:0] b,
  output nzcv_t                flags
);

  localparam int W   = EXP_W + MAN_W + 1;
  localparam int MSB = W - 1;

  logic [MSB-1:0] mag_a, mag_b;
  logic           sgn_a, sgn_b;
  logic           nan_a, nan_b;
  logic           eq, lt, gt;

  always_comb begin
    sgn_a = a[MSB];
    sgn_b = b[MSB];
    mag_a = a[MSB-1:0];
    mag_b = b[MSB-1:0];
    nan_a = (&a[MSB-1:MAN_W]) && (|a[MAN_W-1:0]);
    nan_b = (&b[MSB-1:MAN_W]) && (|b[MAN_W-1:0]);
    eq    = (a == b) || ((mag_a == '0) && (mag_b == '0));
    lt    = 1'b0;
    if (!eq) begin
      if (sgn_a != sgn_b)  lt = sgn_a;
      else if (!sgn_a)     lt = (mag_a < mag_b);
      else                 lt = (mag_a > mag_b);
    end
    gt = !eq && !lt;
    if (nan_a || nan_b) begin
      eq = 1'b0;
      lt = 1'b0;
      gt = 1'b0;
    end
    flags.n = lt;
    flags.z = eq;
    flags.c = gt;
    flags.v = 1'b0;
  end

endmodule

// File: rtl/cmp_flag_unit.sv
module cmp_flag_unit
  import cfu_pkg::*;
#(
  parameter int         DATA_W     = 64,
  parameter int         OPC_W      = 3,
  parameter logic [2:0] OPC_NARROW = 3'd4,
  parameter logic [2:0] OPC_WIDE   = 3'd5,
  parameter int         SP_EXP_W   = 8,
  parameter int         SP_MAN_W   = 23,
  parameter int         DP_EXP_W   = 11,
  parameter int         DP_MAN_W   = 52
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic              bank_int_i,
  input  logic [OPC_W-1:0]  opcode_i,
  input  logic [DATA_W-1:0] opnd_a_i,
  input  logic [DATA_W-1:0] opnd_b_i,
  output logic              done_o,
  output logic              illegal_o,
  output logic [31:0]       status_o
);

  localparam int HALF_W = DATA_W / 2;
  localparam int SP_W   = SP_EXP_W + SP_MAN_W + 1;
  localparam int DP_W   = DP_EXP_W + DP_MAN_W + 1;

  cmp_kind_e kind;
  logic      legal;
  nzcv_t     f_i32, f_i64, f_f32, f_f64, f_sel;

  cfu_decode #(
    .OPC_W(OPC_W), .OPC_NARROW(OPC_NARROW), .OPC_WIDE(OPC_WIDE)
  ) u_dec (
    .bank_int(bank_int_i), .opcode(opcode_i), .kind(kind), .legal(legal)
  );

  cfu_int_cmp #(.W(HALF_W)) u_i32 (
    .a(opnd_a_i[HALF_W-1:0]), .b(opnd_b_i[HALF_W-1:0]), .flags(f_i32)
  );

  cfu_int_cmp #(.W(DATA_W)) u_i64 (
    .a(opnd_a_i), .b(opnd_b_i), .flags(f_i64)
  );

  cfu_fp_cmp #(.EXP_W(SP_EXP_W), .MAN_W(SP_MAN_W)) u_f32 (
    .a(opnd_a_i[DATA_W-1 -: SP_W]), .b(opnd_b_i[DATA_W-1 -: SP_W]), .flags(f_f32)
  );

  cfu_fp_cmp #(.EXP_W(DP_EXP_W), .MAN_W(DP_MAN_W)) u_f64 (
    .a(opnd_a_i[DP_W-1:0]), .b(opnd_b_i[DP_W-1:0]), .flags(f_f64)
  );

  // next-state
  logic        done_d, illegal_d, status_en;
  logic [31:0] status_d;
  logic        done_q, illegal_q;
  logic [31:0] status_q;

  always_comb begin
    unique case (kind)
      KIND_I32: f_sel = f_i32;
      KIND_I64: f_sel = f_i64;
      KIND_F32: f_sel = f_f32;
      default:  f_sel = f_f64;
    endcase
    status_d        = '0;
    status_d[BIT_N] = f_sel.n;
    status_d[BIT_Z] = f_sel.z;
    status_d[BIT_C] = f_sel.c;
    status_d[BIT_V] = f_sel.v;
    status_en       = valid_i && legal;
    done_d          = valid_i && legal;
    illegal_d       = valid_i && !legal;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q    <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      done_q    <= done_d;
      illegal_q <= illegal_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         status_q <= '0;
    else if (status_en) status_q <= status_d;
  end

  assign done_o    = done_q;
  assign illegal_o = illegal_q;
  assign status_o  = status_q;

  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) status_q[27:0] == '0); // R1
  AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n) (valid_i && legal) |=> done_q); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) (done_q && !(valid_i && legal)) |=> !done_q); // R10
  AST_ILLEGAL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) illegal_q |-> $stable(status_q)); // R11
  AST_PULSES_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(done_q && illegal_q)); // R11
  AST_Z_NOT_N: assert property (@(posedge clk) disable iff (!rst_n) done_q |-> !(status_q[BIT_N] && status_q[BIT_Z])); // R3
  AST_FP_V_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (valid_i && legal && !bank_int_i) |=> (!status_q[BIT_V] && $onehot0(status_q[31:29]))); // R7

endmodule

// File: tb/cmp_flag_unit_tb.sv
module cmp_flag_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid_i, bank_int_i;
  logic [2:0]  opcode_i;
  logic [63:0] opnd_a_i, opnd_b_i;
  logic        done_o, illegal_o;
  logic [31:0] status_o;

  int n_checks = 0;
  int n_errors = 0;

  always #2 clk = ~clk;

  cmp_flag_unit dut_i (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .bank_int_i(bank_int_i),
    .opcode_i(opcode_i), .opnd_a_i(opnd_a_i), .opnd_b_i(opnd_b_i),
    .done_o(done_o), .illegal_o(illegal_o), .status_o(status_o)
  );

  // reference model state
  logic        m_done, m_illegal;
  logic [31:0] m_status;

  function automatic logic [3:0] int_ref(input logic wide, input logic [63:0] a, input logic [63:0] b);
    logic signed [64:0] fa, fb, fr;
    logic [63:0] ua, ub;
    logic n, z, c, v;
    if (wide) begin
      ua = a; ub = b;
      fa = {a[63], a}; fb = {b[63], b};
    end else begin
      ua = {32'd0, a[31:0]}; ub = {32'd0, b[31:0]};
      fa = {{33{a[31]}}, a[31:0]}; fb = {{33{b[31]}}, b[31:0]};
    end
    fr = fa - fb;
    if (wide) begin
      n = fr[63]; z = (fr[63:0] == 0);
      v = (fr > 65'sh0_7FFF_FFFF_FFFF_FFFF) || (fr < -65'sh0_8000_0000_0000_0000);
    end else begin
      n = fr[31]; z = (fr[31:0] == 0);
      v = (fr > 65'sd2147483647) || (fr < -65'sd2147483648);
    end
    c = (ua >= ub);
    return {n, z, c, v};
  endfunction

  function automatic real sp_val(input logic [31:0] x);
    int  e;
    real m, r;
    e = int'(x[30:23]);
    m = real'(x[22:0]);
    if (e == 255)    r = 1.0e300;
    else if (e == 0) r = m * (2.0 ** (-149));
    else             r = (1.0 + m / 8388608.0) * (2.0 ** (e - 127));
    return x[31] ? -r : r;
  endfunction

  function automatic logic [3:0] fp_ref(input logic dbl, input logic [63:0] a, input logic [63:0] b);
    real ra, rb;
    logic nan;
    if (dbl) begin
      nan = ((a[62:52] == 11'h7FF) && (a[51:0] != 0)) || ((b[62:52] == 11'h7FF) && (b[51:0] != 0));
      ra = $bitstoreal(a); rb = $bitstoreal(b);
    end else begin
      nan = ((a[62:55] == 8'hFF) && (a[54:32] != 0)) || ((b[62:55] == 8'hFF) && (b[54:32] != 0));
      ra = sp_val(a[63:32]); rb = sp_val(b[63:32]);
    end
    if (nan) return 4'b0000;
    return {ra < rb, ra == rb, ra > rb, 1'b0};
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare_all(input string req);
    check(req, "done", {31'd0, done_o}, {31'd0, m_done});
    check(req, "illegal", {31'd0, illegal_o}, {31'd0, m_illegal});
    check(req, "status", status_o, m_status);
  endtask

  // drive one cycle, update model at the edge, compare after it
  task automatic step(input string req, input logic v, input logic bi, input logic [2:0] op,
                      input logic [63:0] a, input logic [63:0] b);
    logic [3:0] f;
    valid_i = v; bank_int_i = bi; opcode_i = op; opnd_a_i = a; opnd_b_i = b;
    @(posedge clk);
    m_done = 1'b0; m_illegal = 1'b0;
    if (v) begin
      if (op == 3'd4 || op == 3'd5) begin
        f = bi ? int_ref(op == 3'd5, a, b) : fp_ref(op == 3'd5, a, b);
        m_status = {f, 28'd0};
        m_done = 1'b1;
      end else begin
        m_illegal = 1'b1;
      end
    end
    @(negedge clk);
    compare_all(req);
  endtask

  initial begin
    #(4 * 20000);
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; valid_i = 1'b0; bank_int_i = 1'b0; opcode_i = '0;
    opnd_a_i = '0; opnd_b_i = '0;
    m_done = 1'b0; m_illegal = 1'b0; m_status = '0;
    repeat (3) @(negedge clk);
    compare_all("R12");
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R12");

    // R3 R5 32-bit basic orderings, junk in upper halves (R6)
    step("R3", 1, 1, 3'd4, 64'hDEAD_BEEF_0000_0005, 64'h1234_5678_0000_0003);
    check("R5", "gt flags", status_o, 32'h2000_0000);
    step("R3", 1, 1, 3'd4, 64'h0000_0000_0000_0003, 64'hFFFF_FFFF_0000_0005);
    check("R3", "lt flags", status_o, 32'h8000_0000);
    step("R6", 1, 1, 3'd4, 64'hAAAA_AAAA_1234_0000, 64'h5555_5555_1234_0000);
    check("R6", "eq flags", status_o, 32'h6000_0000);
    // R4 overflow 32-bit: min - 1
    step("R4", 1, 1, 3'd4, 64'h0000_0000_8000_0000, 64'h0000_0000_0000_0001);
    check("R4", "ovf32", status_o, 32'h3000_0000);
    step("R4", 1, 1, 3'd4, 64'h0000_0000_7FFF_FFFF, 64'h0000_0000_FFFF_FFFF);
    // R2 64-bit: upper halves matter
    step("R2", 1, 1, 3'd5, 64'h0000_0001_0000_0000, 64'h0000_0000_0000_0001);
    check("R2", "wide gt", status_o, 32'h2000_0000);
    step("R4", 1, 1, 3'd5, 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0001);
    check("R4", "ovf64", status_o, 32'h3000_0000);
    step("R5", 1, 1, 3'd5, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001);
    step("R3", 1, 1, 3'd5, 64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF);

    // R7 single precision in upper half, junk below (R6)
    step("R7", 1, 0, 3'd4, 64'h3F80_0000_FFFF_FFFF, 64'h4000_0000_0000_0000);
    check("R7", "sp lt", status_o, 32'h8000_0000);
    step("R7", 1, 0, 3'd4, 64'hBF80_0000_0000_0000, 64'hC000_0000_1111_1111);
    check("R7", "sp neg gt", status_o, 32'h2000_0000);
    step("R7", 1, 0, 3'd4, 64'h4049_0FDB_0000_0001, 64'h4049_0FDB_0000_0002);
    step("R8", 1, 0, 3'd4, 64'h0000_0000_0000_0000, 64'h8000_0000_0000_0000);
    check("R8", "sp zeros", status_o, 32'h4000_0000);
    step("R9", 1, 0, 3'd4, 64'h7FC0_0000_0000_0000, 64'h3F80_0000_0000_0000);
    check("R9", "sp nan", status_o, 32'h0000_0000);
    step("R7", 1, 0, 3'd4, 64'h7F80_0000_0000_0000, 64'h7F7F_FFFF_0000_0000);
    step("R7", 1, 0, 3'd4, 64'h0000_0001_0000_0000, 64'h8000_0001_0000_0000);

    // double precision
    step("R2", 1, 0, 3'd5, 64'h3FF0_0000_0000_0000, 64'h4000_0000_0000_0000);
    check("R2", "dp lt", status_o, 32'h8000_0000);
    step("R7", 1, 0, 3'd5, 64'hC000_0000_0000_0000, 64'hBFF0_0000_0000_0000);
    step("R8", 1, 0, 3'd5, 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0000);
    step("R9", 1, 0, 3'd5, 64'h3FF0_0000_0000_0000, 64'h7FF8_0000_0000_0000);
    check("R9", "dp nan", status_o, 32'h0000_0000);
    step("R7", 1, 0, 3'd5, 64'h4000_0000_0000_0001, 64'h4000_0000_0000_0000);

    // set a known status, then illegal and idle cycles must leave it
    step("R10", 1, 1, 3'd4, 64'd7, 64'd9);
    step("R11", 1, 1, 3'd3, 64'd1, 64'd1);
    check("R11", "held status", status_o, 32'h8000_0000);
    step("R11", 1, 0, 3'd7, 64'd0, 64'd5);
    step("R10", 0, 1, 3'd4, 64'd5, 64'd5);
    check("R10", "idle held", status_o, 32'h8000_0000);
    step("R10", 0, 0, 3'd5, 64'd0, 64'd0);

    // back-to-back requests
    for (int i = 0; i < 40; i++) begin
      step("R10", 1, i[0], 3'd4 + {2'd0, i[1]},
           {i[7:0] * 8'h3B, 24'h0, i[7:0] * 8'h5D, 24'h0} ^ 64'h3F80_0000_0000_0000,
           {i[7:0] * 8'h17, 24'h0, i[7:0] * 8'hC3, 24'h0} ^ 64'h3F80_0000_0000_0000);
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule